// File: doc/BRIEF.md
# Watchdog Timer with Guarded Control Writes

This block supervises software by counting strobes of a slow, millisecond-scale tick. If software does not service it in time, it either asks for a system reset or raises an interrupt. One 8-bit control register holds the timeout selector, the enable, the reaction mode, a sticky timeout flag and an unlock bit. Software reaches it through a simple write port and read port.

The register cannot be changed by a single stray store. Software first writes a byte with the unlock bit set, and that write only arms the guard. The very next access must be a write, and that write is the one that lands. Every accepted write also restarts the count, so a periodic two-write sequence is how the watchdog is kept quiet. In reset mode a timeout gives a one-cycle reset request and returns the control fields to their idle values. The timeout flag is kept, so software can tell after the restart why the system was reset.

Top module: `wdg_guard`

## Requirements
- R1: After the synchronous reset `rst`, `rst_req_o` and `irq_o` are low and a read returns 0x00.
- R2: The control byte is laid out as: bits 3:0 selector, bit 4 enable, bit 5 interrupt mode, bit 6 timeout flag, bit 7 unlock. With the enable set, selector code k in 0..7 times out on the (2^(BASE_LOG2+k))-th tick strobe after the last accepted write. With the default BASE_LOG2 = 4 that is 16 to 2048 ticks. The request output rises on the clock edge that takes the final tick.
- R3: Selector codes 9 to 15 behave exactly like code 7.
- R4: While the guard is not armed, a write with bit 7 = 1 only arms it, and a write with bit 7 = 0 is ignored. In neither case does the register change.
- R5: While the guard is armed, the next write is accepted whatever its bit 7, and the guard disarms. A read without a write disarms it and nothing is written. Read data bit 7 shows the armed state.
- R6: Every accepted write clears the tick count, so servicing before the limit prevents a timeout.
- R7: Selector code 8 with the enable set times out on the first clock edge after it is accepted, with no tick needed.
- R8: In reset mode (bit 5 = 0) a timeout drives `rst_req_o` high for exactly one cycle. It clears bits 5:0 of the register and sets the timeout flag.
- R9: In interrupt mode (bit 5 = 1) a timeout pulses `irq_o` for one cycle and never `rst_req_o`. The configuration is kept and counting starts again from zero.
- R10: The timeout flag is set only by a timeout. An accepted write with bit 6 = 0 clears it, and one with bit 6 = 1 leaves it unchanged.
- R11: With the enable clear, ticks are not counted and neither request output is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | One-cycle strobe of the timeout time base |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_en_i | input | 1 | Control register read strobe |
| rd_data_o | output | 8 | Registered read data, valid the cycle after `rd_en_i` |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle watchdog interrupt request |

## Verification
A write takes effect on the edge that samples it, and read data appears on the cycle after `rd_en_i`. Each request output rises one register stage after its cause: on the edge that takes the terminal tick, or on the first edge after an immediate-timeout setting is accepted. Both return low on the following edge. The bench drives on falling edges and checks on the falling edge right after the edge that was due. Every timeout is checked twice: one tick short of the limit, where the output must still be quiet, and again on the terminal tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned SEL_W        = 4;
  localparam int unsigned NUM_PERIODS  = 8;
  localparam logic [SEL_W-1:0] SEL_IMMEDIATE = 4'd8;
  localparam logic [SEL_W-1:0] SEL_LONGEST   = 4'd7;

  // Software-visible field layout, bit 6 down to bit 0.
  typedef struct packed {
    logic             status;
    logic             irq_mode;
    logic             enable;
    logic [SEL_W-1:0] sel;
  } wdg_cfg_t;

  // Map a selector code onto a period index; reserved codes take the longest.
  function automatic logic [2:0] period_index(input logic [SEL_W-1:0] code);
    logic [2:0] idx;
    if (code > SEL_LONGEST) idx = 3'(SEL_LONGEST);
    else                    idx = code[2:0];
    return idx;
  endfunction

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock (
  input  logic clk,
  input  logic rst,
  input  logic wr_en_i,
  input  logic rd_en_i,
  input  logic arm_bit_i,
  output logic armed_o,
  output logic accept_o
);

  logic armed_q;

  // A write while armed is the one that lands.
  assign accept_o = wr_en_i & armed_q;
  assign armed_o  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (wr_en_i) begin
      // Armed: this write consumes the guard. Not armed: bit 7 arms it.
      armed_q <= armed_q ? 1'b0 : arm_bit_i;
    end else if (rd_en_i) begin
      armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept_i,
  input  logic [6:0] wr_data_i,
  input  logic       fire_i,
  output wdg_cfg_t   cfg_o
);

  wdg_cfg_t cfg_q;
  wdg_cfg_t wr_cfg;

  assign wr_cfg = wdg_cfg_t'(wr_data_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (accept_i) begin
      cfg_q.sel      <= wr_cfg.sel;
      cfg_q.enable   <= wr_cfg.enable;
      cfg_q.irq_mode <= wr_cfg.irq_mode;
      // Software may clear the flag but never set it.
      cfg_q.status   <= cfg_q.status & wr_cfg.status;
    end else if (fire_i) begin
      cfg_q.status <= 1'b1;
      if (!cfg_q.irq_mode) begin
        // The requested system reset returns the fields to idle; the flag stays.
        cfg_q.sel      <= '0;
        cfg_q.enable   <= 1'b0;
        cfg_q.irq_mode <= 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic             fire_o
);

  localparam int unsigned CW = BASE_LOG2 + NUM_PERIODS;

  logic [CW-1:0] last_cnt [NUM_PERIODS];
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx;
  logic          immediate;
  logic          terminal;

  // Terminal count for each period code: 2^(BASE_LOG2+k) - 1.
  for (genvar k = 0; k < NUM_PERIODS; k++) begin : g_limit
    assign last_cnt[k] = (CW'(1) << (BASE_LOG2 + k)) - CW'(1);
  end

  assign idx       = period_index(sel_i);
  assign immediate = (sel_i == SEL_IMMEDIATE);
  assign terminal  = tick_i && (cnt_q == last_cnt[idx]);
  assign fire_o    = enable_i && !restart_i && (immediate || terminal);

  always_ff @(posedge clk) begin
    if (rst || restart_i || !enable_i || fire_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_o,
  output logic       irq_o
);

  logic     armed;
  logic     accept;
  logic     fire;
  wdg_cfg_t cfg;
  logic [7:0] rd_q;
  logic       rst_req_q;
  logic       irq_q;

  wdg_unlock u_unlock (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .arm_bit_i (wr_data_i[7]),
    .armed_o   (armed),
    .accept_o  (accept)
  );

  wdg_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .wr_data_i (wr_data_i[6:0]),
    .fire_i    (fire),
    .cfg_o     (cfg)
  );

  wdg_counter #(
    .BASE_LOG2 (BASE_LOG2)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (cfg.enable),
    .sel_i     (cfg.sel),
    .tick_i    (tick_i),
    .restart_i (accept),
    .fire_o    (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      rst_req_q <= fire & ~cfg.irq_mode;
      irq_q     <= fire &  cfg.irq_mode;
      if (rd_en_i) rd_q <= {armed, cfg};
    end
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk
  import wdg_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     wr_en_i,
  input logic     rd_en_i,
  input logic     rst_req_o,
  input logic     irq_o,
  input logic     armed,
  input logic     fire,
  input wdg_cfg_t cfg
);

  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  assert_one_reaction_R9: assert property (@(posedge clk) disable iff (rst)
    !(rst_req_o && irq_o));

  assert_flag_on_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o || irq_o) |-> cfg.status);

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !armed && !fire) |=> (cfg == $past(cfg)));

  assert_read_disarms_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i) |=> !armed);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg.enable |=> (!rst_req_o && !irq_o));

  assert_immediate_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.enable && cfg.sel == SEL_IMMEDIATE && !(wr_en_i && armed))
      |=> (rst_req_o || irq_o));

endmodule

bind wdg_guard wdg_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .armed     (armed),
  .fire      (fire),
  .cfg       (cfg)
);

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 10;
  // Each entry: {selector code, ticks to timeout with BASE_LOG2 = 4}.
  localparam logic [15:0] VEC [VEC_N] = '{
    {4'd0, 12'd16},   {4'd1, 12'd32},   {4'd2, 12'd64},   {4'd3, 12'd128},
    {4'd4, 12'd256},  {4'd5, 12'd512},  {4'd6, 12'd1024}, {4'd7, 12'd2048},
    {4'd9, 12'd2048}, {4'd15, 12'd2048}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rst_req_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_guard #(.BASE_LOG2(4)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic guarded_write(input logic [7:0] d);
    do_write(8'h80);
    do_write(d);
  endtask

  task automatic do_read(output logic [7:0] q);
    @(negedge clk); rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0; q = rd_data_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
    end
    @(negedge clk); tick_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rst_req", 32'(rst_req_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    do_read(rd); chk("R1 readback", 32'(rd), 32'h00);

    // R4 unguarded write ignored
    do_write(8'h10);
    do_read(rd); chk("R4 unguarded write", 32'(rd), 32'h00);
    ticks(40); chk("R4 no timeout", 32'(rst_req_o), 0);

    // R5 armed visible, read cancels the unlock
    do_write(8'h80);
    do_read(rd); chk("R5 armed bit", 32'(rd), 32'h80);
    do_write(8'h10);
    do_read(rd); chk("R5 read cancels", 32'(rd), 32'h00);

    // R2 / R3 / R8 period table, reset mode
    for (int i = 0; i < VEC_N; i++) begin
      guarded_write(8'h10 | 8'(VEC[i][15:12]));
      ticks(int'(VEC[i][11:0]) - 1);
      chk("R2 R3 early", 32'(rst_req_o), 0);
      ticks(1);
      chk("R2 R3 terminal", 32'(rst_req_o), 1);
      chk("R8 no irq", 32'(irq_o), 0);
      @(negedge clk); chk("R8 pulse width", 32'(rst_req_o), 0);
      do_read(rd); chk("R8 R10 fields after reset", 32'(rd), 32'h40);
      guarded_write(8'h00);
      do_read(rd); chk("R10 flag cleared", 32'(rd), 32'h00);
    end

    // R10 write cannot set the flag
    guarded_write(8'h40);
    do_read(rd); chk("R10 write no set", 32'(rd), 32'h00);

    // R6 servicing restarts the count
    guarded_write(8'h10);
    ticks(10);
    guarded_write(8'h10);
    ticks(15); chk("R6 serviced", 32'(rst_req_o), 0);
    ticks(1);  chk("R6 after service", 32'(rst_req_o), 1);
    guarded_write(8'h00);

    // R7 immediate code
    guarded_write(8'h18);
    chk("R7 not yet", 32'(rst_req_o), 0);
    @(negedge clk); chk("R7 immediate", 32'(rst_req_o), 1);
    @(negedge clk); chk("R7 R8 single pulse", 32'(rst_req_o), 0);
    do_read(rd); chk("R7 readback", 32'(rd), 32'h40);
    guarded_write(8'h00);

    // R9 interrupt mode
    guarded_write(8'h30);
    ticks(16);
    chk("R9 irq", 32'(irq_o), 1);
    chk("R9 no reset", 32'(rst_req_o), 0);
    @(negedge clk); chk("R9 irq pulse", 32'(irq_o), 0);
    do_read(rd); chk("R9 config kept", 32'(rd), 32'h70);
    ticks(15); chk("R9 restart early", 32'(irq_o), 0);
    ticks(1);  chk("R9 restart terminal", 32'(irq_o), 1);
    guarded_write(8'h00);
    do_read(rd); chk("R10 clear after irq", 32'(rd), 32'h00);

    // R11 disabled
    guarded_write(8'h00);
    ticks(100);
    chk("R11 no reset", 32'(rst_req_o), 0);
    chk("R11 no irq", 32'(irq_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule